// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A free-running clock-cycle counter produces a baud tick whenever it reaches a divisor. The divisor is assembled from a high part and a low part, with the high part on top. Every bit of the frame is held on the line for exactly one tick period, and every change on the line lands on a tick.

The frame shape is chosen by configuration inputs:
- a character length of 6, 7 or 8 bits;
- a parity bit that can be left out or set in one of four ways;
- one or two stop bits.

A producer offers a character with a valid/ready handshake. The block takes it only when it is idle. At that moment the character and the whole frame shape are captured, so later changes to the configuration inputs do not disturb a frame already accepted.

An optional flow-control gate holds the start of a captured frame back until the active-low clear-to-send input is low. A busy output shows that a character is held or being sent.

Top module: `ser_tx`

## Requirements
- R1: After reset, the line is at 1, `busy` is 0 and `in_ready` is 1.
- R2: Each bit of a frame occupies exactly `{cfg_div_hi, cfg_div_lo} + 1` clock cycles on `txd`, and `txd` changes only on a baud tick.
- R3: A frame begins with a 0 start bit, followed by the data bits least significant first. The number of data bits comes from `cfg_char_len`: code 0 gives 6 bits, code 1 gives 7 bits, and codes 2 and 3 give 8 bits.
- R4: With `cfg_par_en` = 1, one parity bit follows the data, chosen by `cfg_par_mode`:
  - mode 1: the XOR of the active data bits;
  - mode 0: the inverse of that XOR;
  - mode 2: a constant 1;
  - mode 3: a constant 0.

  With `cfg_par_en` = 0, no parity bit is sent.
- R5: One stop bit at 1 is sent, or two when `cfg_two_stop` = 1. A frame therefore lasts 1 + data bits + parity enable + stop count bit periods. `busy` drops exactly at the end of the last stop bit, and the line then stays at 1.
- R6: A character is accepted only on a cycle where `in_valid` and `in_ready` are both 1. After acceptance, `busy` is 1 and `in_ready` is 0 until the frame ends, and `in_valid` pulses during that time are ignored.
- R7: When flow control was enabled at acceptance, the start bit is not sent while `cts_n` is 1. It begins on the first baud tick at which `cts_n` is 0.
- R8: When flow control was disabled at acceptance, the start bit begins on the first baud tick after acceptance, whatever the level of `cts_n`.
- R9: The character and every frame-shape input are captured at acceptance. Changing them during the frame does not change the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div_hi | input | HI_W | Upper part of the baud divisor |
| cfg_div_lo | input | LO_W | Lower part of the baud divisor |
| cfg_char_len | input | 2 | Character length code (0: 6 bits, 1: 7 bits, 2 or 3: 8 bits) |
| cfg_par_en | input | 1 | Send a parity bit |
| cfg_par_mode | input | 2 | Parity rule (0 inverted XOR, 1 XOR, 2 constant 1, 3 constant 0) |
| cfg_two_stop | input | 1 | Send two stop bits instead of one |
| cfg_flow_en | input | 1 | Gate the frame start on clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low |
| in_valid | input | 1 | Character offered |
| in_data | input | DATA_W | Character to send |
| in_ready | output | 1 | Block is idle and can take a character |
| txd | output | 1 | Serial transmit line, idle level 1 |
| busy | output | 1 | A character is held or being sent |

## Verification
The main sweep sends two characters with different bit patterns in every combination of the three character lengths, the five parity settings (parity off and the four modes) and both stop counts. Each cycle of each frame is compared with a frame computed in the bench, so a wrong bit order, a wrong parity rule, a wrong frame length or a wrong bit period each produces a different mismatch.

The same sweep scrambles the configuration and pulses `in_valid` in the middle of the frames, which separates frame shapes captured at acceptance from frame shapes read live. Three divisor settings follow:
- a zero divisor, giving one-cycle bits;
- a small divisor;
- a divisor with a non-zero high part, which shows whether the two divisor parts are joined in the right order.

Finally, clear-to-send is held inactive with flow control on and then with flow control off, which tells a working gate from a missing one and from one that is applied when it should not be.

// File: rtl/ser_tx_pkg.sv
// Package: shared types and constants for the serial transmitter.
// Assumes characters are at most 8 bits wide.
package ser_tx_pkg;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } tx_state_t;

    // Character length codes seen on cfg_char_len.
    localparam logic [1:0] LEN_SHORT = 2'd0;   // two bits fewer than DATA_W
    localparam logic [1:0] LEN_MID   = 2'd1;   // one bit fewer than DATA_W

    // Parity rule codes seen on cfg_par_mode.
    localparam logic [1:0] PAR_INV_XOR = 2'd0;
    localparam logic [1:0] PAR_XOR     = 2'd1;
    localparam logic [1:0] PAR_ONE     = 2'd2;
    localparam logic [1:0] PAR_ZERO    = 2'd3;

endpackage

// File: rtl/ser_tx_baud.sv
// Module: baud tick generator.
// A free-running counter that pulses tick for one cycle when it equals
// the divisor {div_hi, div_lo}, and clears on that same cycle.
// Assumes the divisor is quasi-static; a divisor lowered below the
// current count makes the counter wrap once before ticking again.
module ser_tx_baud #(
    parameter int HI_W = 8,
    parameter int LO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HI_W-1:0] div_hi,
    input  logic [LO_W-1:0] div_lo,
    output logic            tick
);
    localparam int CNT_W = HI_W + LO_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_full;

    // Join the two divisor parts, high part on top.
    assign div_full = {div_hi, div_lo};
    assign tick     = (cnt_q == div_full);

    // Count clock cycles and clear on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ser_tx_frame_build.sv
// Module: frame builder.
// Purely combinational. From a character and the frame-shape inputs it
// forms the full bit sequence (LSB is sent first) and its length in bits.
// Bit positions past the frame length are 1, so stop bits come for free.
// Assumes DATA_W >= 3, so that the short character length is at least 1 bit.
module ser_tx_frame_build
    import ser_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 4,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic [1:0]         char_len,
    input  logic               par_en,
    input  logic [1:0]         par_mode,
    input  logic               two_stop,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   frame_len
);
    logic [LEN_W-1:0]  n_data;
    logic [DATA_W-1:0] data_mask;
    logic              xor_bits;
    logic              par_bit;

    // Decode the character length code into a data bit count.
    always_comb begin
        case (char_len)
            LEN_SHORT: n_data = LEN_W'(DATA_W - 2);
            LEN_MID:   n_data = LEN_W'(DATA_W - 1);
            default:   n_data = LEN_W'(DATA_W);
        endcase
    end

    // Mask selecting the active data bits.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            data_mask[i] = (LEN_W'(i) < n_data);
        end
    end

    // Choose the parity bit from the selected rule.
    always_comb begin
        xor_bits = ^(data & data_mask);
        case (par_mode)
            PAR_XOR:     par_bit = xor_bits;
            PAR_INV_XOR: par_bit = ~xor_bits;
            PAR_ONE:     par_bit = 1'b1;
            default:     par_bit = 1'b0;
        endcase
    end

    // Place start, data and parity bits; everything else stays 1.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int k = 1; k < FRAME_W; k++) begin
            if (LEN_W'(k) <= n_data) begin
                frame[k] = data[k-1];
            end else if (par_en && (LEN_W'(k) == n_data + 1'b1)) begin
                frame[k] = par_bit;
            end
        end
    end

    // Total bit periods: start + data + parity + stop bits.
    assign frame_len = LEN_W'(1) + n_data + LEN_W'(par_en)
                     + (two_stop ? LEN_W'(2) : LEN_W'(1));
endmodule

// File: rtl/ser_tx_fsm.sv
// Module: transmit sequencer.
// Captures a built frame on handshake acceptance, waits for a baud tick
// (and clear-to-send when flow control was enabled), then shifts one bit
// onto the line per tick. After the last stop bit has been held for a full
// period it returns to idle with the line at 1.
// Assumes tick is a one-cycle pulse.
module ser_tx_fsm
    import ser_tx_pkg::*;
#(
    parameter int FRAME_W = 12,
    parameter int LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   len_in,
    input  logic               flow_en,
    input  logic               cts_n,
    input  logic               tick,
    output logic               in_ready,
    output logic               busy,
    output logic               txd,
    output logic               flow_q
);
    tx_state_t          st_q;
    logic [FRAME_W-1:0] shift_q;
    logic [LEN_W-1:0]   left_q;
    logic               go_ok;

    // Start may go ahead when the gate is off or clear-to-send is low.
    assign go_ok    = !flow_q || !cts_n;
    assign in_ready = (st_q == ST_IDLE);
    assign busy     = (st_q != ST_IDLE);

    // State, shift register, remaining-bit count and line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            shift_q <= '1;
            left_q  <= '0;
            flow_q  <= 1'b0;
            txd     <= 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        shift_q <= frame_in;
                        left_q  <= len_in;
                        flow_q  <= flow_en;
                        st_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (tick && go_ok) begin
                        txd     <= shift_q[0];
                        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                        left_q  <= left_q - 1'b1;
                        st_q    <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (left_q == '0) begin
                            txd  <= 1'b1;
                            st_q <= ST_IDLE;
                        end else begin
                            txd     <= shift_q[0];
                            shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                            left_q  <= left_q - 1'b1;
                        end
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                    txd  <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ser_tx.sv
// Module: serial character transmitter, top level.
// Ties together the baud tick generator, the frame builder and the
// transmit sequencer. Configuration inputs are read when a character is
// accepted, except the divisor, which is used live.
// Assumes a single clock domain and a synchronous active-low reset.
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int HI_W   = 8,
    parameter int LO_W   = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HI_W-1:0]   cfg_div_hi,
    input  logic [LO_W-1:0]   cfg_div_lo,
    input  logic [1:0]        cfg_char_len,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    input  logic              cfg_two_stop,
    input  logic              cfg_flow_en,
    input  logic              cts_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);
    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic               tick;
    logic               fc_lat;
    logic [FRAME_W-1:0] frame_w;
    logic [LEN_W-1:0]   len_w;

    // Bit-period tick source.
    ser_tx_baud #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_hi (cfg_div_hi),
        .div_lo (cfg_div_lo),
        .tick   (tick)
    );

    // Frame assembly from the offered character and live shape inputs.
    ser_tx_frame_build #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) u_build (
        .data      (in_data),
        .char_len  (cfg_char_len),
        .par_en    (cfg_par_en),
        .par_mode  (cfg_par_mode),
        .two_stop  (cfg_two_stop),
        .frame     (frame_w),
        .frame_len (len_w)
    );

    // Handshake, flow-control gate and bit shifting.
    ser_tx_fsm #(
        .FRAME_W (FRAME_W),
        .LEN_W   (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .frame_in (frame_w),
        .len_in   (len_w),
        .flow_en  (cfg_flow_en),
        .cts_n    (cts_n),
        .tick     (tick),
        .in_ready (in_ready),
        .busy     (busy),
        .txd      (txd),
        .flow_q   (fc_lat)
    );
endmodule

// File: rtl/ser_tx_chk.sv
// Module: property checker for the serial transmitter, bound to ser_tx.
// Observes ports plus the baud tick and the captured flow-control flag.
module ser_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic busy,
    input logic in_valid,
    input logic in_ready,
    input logic cts_n,
    input logic fc_lat,
    input logic tick
);
    // R1: the first cycle out of reset shows an idle, high line.
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (txd && !busy && in_ready));

    // R2: the line only moves on the cycle after a baud tick.
    a_r2_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> $past(tick));

    // R3: a start bit only appears while a frame is in progress.
    a_r3_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> busy);

    // R5: whenever the block is idle the line rests at 1.
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R6: an accepted character makes the block busy on the next cycle.
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !in_ready));

    // R7: with the gate captured on, a start bit needs clear-to-send low.
    a_r7_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(txd) && fc_lat) |-> !$past(cts_n));
endmodule

bind ser_tx ser_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .busy     (busy),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .cts_n    (cts_n),
    .fc_lat   (fc_lat),
    .tick     (tick)
);

// File: tb/ser_tx_bench.sv
// Bench: sweeps every frame shape at small divisors and checks each cycle
// of each frame against a frame computed here from the requirements.
module ser_tx_bench;
    localparam int HI_W   = 4;
    localparam int LO_W   = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [HI_W-1:0]   cfg_div_hi = '0;
    logic [LO_W-1:0]   cfg_div_lo = '0;
    logic [1:0]        cfg_char_len = '0;
    logic              cfg_par_en = 1'b0;
    logic [1:0]        cfg_par_mode = '0;
    logic              cfg_two_stop = 1'b0;
    logic              cfg_flow_en = 1'b0;
    logic              cts_n = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              txd;
    logic              busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ser_tx #(.HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W)) u_ser_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_div_hi   (cfg_div_hi),
        .cfg_div_lo   (cfg_div_lo),
        .cfg_char_len (cfg_char_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_mode (cfg_par_mode),
        .cfg_two_stop (cfg_two_stop),
        .cfg_flow_en  (cfg_flow_en),
        .cts_n        (cts_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .txd          (txd),
        .busy         (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected frame, computed from the frame rules (R3, R4, R5).
    function automatic void mk_exp(input logic [7:0] d, input logic [1:0] cl,
                                   input logic pe, input logic [1:0] pm,
                                   input logic ts, output logic [11:0] bits,
                                   output int len, output int nd);
        int pos;
        logic x;
        nd = (cl == 2'd0) ? 6 : (cl == 2'd1) ? 7 : 8;
        bits = '1;
        bits[0] = 1'b0;
        x = 1'b0;
        for (int i = 0; i < nd; i++) begin
            bits[1+i] = d[i];
            x = x ^ d[i];
        end
        pos = 1 + nd;
        if (pe) begin
            case (pm)
                2'd0:    bits[pos] = ~x;
                2'd1:    bits[pos] = x;
                2'd2:    bits[pos] = 1'b1;
                default: bits[pos] = 1'b0;
            endcase
            pos++;
        end
        len = pos + (ts ? 2 : 1);
    endfunction

    // Send one character and check the whole frame cycle by cycle.
    task automatic run_frame(input logic [7:0] d, input logic [1:0] cl,
                             input logic pe, input logic [1:0] pm,
                             input logic ts, input logic fc,
                             input int hold, input bit poke);
        logic [11:0] exp_bits;
        int len;
        int nd;
        int per;
        int m;
        bit bad;
        string tag;
        mk_exp(d, cl, pe, pm, ts, exp_bits, len, nd);
        per = (int'(cfg_div_hi) << LO_W) + int'(cfg_div_lo) + 1;
        @(negedge clk);
        cfg_char_len = cl; cfg_par_en = pe; cfg_par_mode = pm;
        cfg_two_stop = ts; cfg_flow_en = fc; in_data = d;
        cts_n = (fc && hold > 0) ? 1'b1 : (fc ? 1'b0 : 1'b1);
        in_valid = 1'b1;
        chk("R6 ready before accept", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 busy after accept", int'(busy), 1);
        // R9: scramble everything the frame was built from.
        cfg_char_len = ~cl; cfg_par_en = ~pe; cfg_par_mode = ~pm;
        cfg_two_stop = ~ts; in_data = ~d;
        if (fc && hold > 0) begin
            bad = 0;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                if (txd !== 1'b1 || busy !== 1'b1) bad = 1;
            end
            chk("R7 held while cts_n high", int'(bad), 0);
            cts_n = 1'b0;
        end
        m = 0;
        while (txd === 1'b1 && m <= per + 1) begin
            @(negedge clk);
            m++;
        end
        chk(fc ? "R7 start within one period of clearance"
               : "R8 start within one period of accept",
            int'(m >= 1 && m <= per), 1);
        for (int j = 0; j < len; j++) begin
            bad = 0;
            for (int k = 0; k < per; k++) begin
                if (j != 0 || k != 0) @(negedge clk);
                if (txd !== exp_bits[j]) bad = 1;
                if (poke && j == 1 && k == 0) begin
                    in_valid = 1'b1;
                    in_data = ~d;
                end
                if (poke && j == 1 && k == 1 % per) in_valid = 1'b0;
                if (j == 1 && k == per - 1) in_valid = 1'b0;
                if (j == len - 1 && k == per - 1)
                    chk("R5 busy through last stop bit", int'(busy), 1);
            end
            if (j == 0) tag = "R2 R3 start bit";
            else if (j <= nd) tag = "R2 R3 R9 data bit";
            else if (pe && j == nd + 1) tag = "R2 R4 R9 parity bit";
            else tag = "R2 R5 R9 stop bit";
            chk(tag, int'(bad), 0);
        end
        @(negedge clk);
        chk("R5 idle after frame", int'(!busy && txd && in_ready), 1);
        bad = 0;
        for (int q = 0; q < 3 * per; q++) begin
            @(negedge clk);
            if (busy !== 1'b0 || txd !== 1'b1) bad = 1;
        end
        chk("R6 ignored valid while busy, line stays idle", int'(bad), 0);
        cts_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] pats [2];
        pats[0] = 8'hA5;
        pats[1] = 8'h3C;
        cfg_div_hi = 4'd0;
        cfg_div_lo = 4'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset ready", int'(in_ready), 1);

        // Full shape sweep; p = 0 means parity off, else mode p-1.
        for (int cl = 0; cl < 3; cl++)
            for (int p = 0; p < 5; p++)
                for (int ts = 0; ts < 2; ts++)
                    for (int di = 0; di < 2; di++)
                        run_frame(pats[di], 2'(cl), (p != 0), 2'(p == 0 ? 0 : p - 1),
                                  1'(ts), 1'b0, 0, (di == 1));
        // Code 3 also selects 8 data bits.
        run_frame(8'h96, 2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 0, 1'b0);

        // Divisor corners: one-cycle bits, then a non-zero high part.
        cfg_div_hi = 4'd0; cfg_div_lo = 4'd0;
        run_frame(8'h5B, 2'd2, 1'b1, 2'd0, 1'b1, 1'b0, 0, 1'b0);
        cfg_div_hi = 4'd1; cfg_div_lo = 4'd2;
        run_frame(8'hC3, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 0, 1'b1);

        // Flow control on with clear-to-send held off, then gate off.
        cfg_div_hi = 4'd0; cfg_div_lo = 4'd3;
        run_frame(8'h71, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 40, 1'b0);
        run_frame(8'h0F, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 7, 1'b1);
        run_frame(8'hE2, 2'd2, 1'b1, 2'd2, 1'b0, 1'b0, 0, 1'b0);

        finish_run();
    end
endmodule